// File: doc/BRIEF.md
# CPU Debug Control Port

This block lets a host on a simple register bus stop, restart, single-step and reset a small 32-bit processor core, and read back the core's internal state while it is stopped. The host sees two 32-bit registers. The control register (address 0) takes command bits and a 6-bit register index. The data register (address 1) returns the captured value of the indexed register, or a live status word while the core runs.

The core side has a halt request, a one-cycle reset pulse, a one-cycle step pulse and a halted acknowledge from the core. It also has two combinational read ports, one into the core's register file and one into its peripheral register set. To read a register, the host writes halt together with the index. It then polls the control register until the ready flag is set, and then reads the data register.

The command state machine has five states:
- `ST_RUN`: the core runs freely.
- `ST_HALT_WAIT`: halt is requested and the block waits for the core to acknowledge it.
- `ST_HALTED`: the core is stopped and the selected register is captured every cycle.
- `ST_STEP`: a one-cycle step pulse is sent to the core.
- `ST_RESET`: a one-cycle reset pulse is sent while halt stays requested.

The transitions are:
- `ST_RUN`: halt or step goes to `ST_HALT_WAIT`, reset goes to `ST_RESET`, and go stays in `ST_RUN`.
- `ST_HALT_WAIT`: the core's acknowledge goes to `ST_HALTED`, go goes to `ST_RUN`, and reset goes to `ST_RESET`.
- `ST_HALTED`: step goes to `ST_STEP`, go goes to `ST_RUN`, reset goes to `ST_RESET`, and halt stays in `ST_HALTED`.
- `ST_STEP` always goes to `ST_HALT_WAIT`.
- `ST_RESET` always goes to `ST_HALT_WAIT`.

Commands written while the machine is in `ST_STEP` or `ST_RESET` are ignored, but the index is still taken. The core must drop its halted acknowledge on the clock edge that follows a step pulse or a reset pulse.

Top module: `dbg_port`

## Requirements
- R1: After reset, the core is released (`core_halt_req`=0), the index is 0, the ready flag is 0, and a read of the control register returns 0.
- R2: Control register write layout: bits [5:0] are the index, bit 8 is halt, bit 9 is step, bit 10 is go and bit 11 is reset. When several command bits are set, reset wins over go, go wins over step, and step wins over halt. On read, the control register returns the index in [5:0], the halt request in bit 8 and the ready flag in bit 12.
- R3: A halt write raises `core_halt_req` on the next cycle. It stays high until go is written.
- R4: A go write in `ST_RUN`, `ST_HALT_WAIT` or `ST_HALTED` drops `core_halt_req` on the next cycle and clears ready.
- R5: A step write while halted gives exactly one single-cycle `core_step` pulse. `core_halt_req` stays high throughout, and ready returns once the core halts again.
- R6: A reset write gives exactly one single-cycle `core_reset` pulse with `core_halt_req` high. The core is then left halted.
- R7: Ready is set only while the core is halted and the value for the current index has been captured. It reads 0 in the cycle after any control write.
- R8: Indices 0 to 31 return the core register value selected by `cpu_reg_sel` = index[4:0]. Indices 0 to 15 are the supervisor registers and indices 16 to 31 are the user registers.
- R9: Indices 32 to 39 and 44 to 47 return the peripheral value selected by `per_sel` = index[3:0].
- R10: Indices 40 to 43 and 48 to 63 return 0.
- R11: While the core is not yet halted again after a halt, step or reset, the data register returns the value captured last.
- R12: While running, the data register returns the status word: bit 16 is external interrupt pending, bit 15 is break enabled, bit 13 is supervisor mode, bit 12 is sleeping, and all other bits are 0.
- R13: A step write while running halts the core and produces no step pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 1 | 0 selects the control register, 1 selects the data register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| core_halt_req | output | 1 | Halt request to the core |
| core_reset | output | 1 | One-cycle reset pulse to the core |
| core_step | output | 1 | One-cycle step pulse to the core |
| core_halted | input | 1 | Core reports that it has stopped |
| cpu_reg_sel | output | 5 | Core register file read index |
| cpu_reg_val | input | 32 | Core register file read value |
| per_sel | output | 4 | Peripheral register read index |
| per_val | input | 32 | Peripheral register read value |
| st_ext_int | input | 1 | External interrupt pending |
| st_break_en | input | 1 | Break enabled |
| st_supervisor | input | 1 | Core in supervisor mode |
| st_sleeping | input | 1 | Core sleeping |

## Verification
The assertions check the following on every cycle:
- The step and reset pulses last exactly one cycle.
- Reset never occurs without halt requested.
- Ready implies that halt is requested, and ready clears after any control write.
- Go releases the core, and a step written while running produces no pulse.
- Unmapped indices read zero.

Only the bench's scenarios, which use a core model with a real execution delay, can show the rest:
- The full index map, including where supervisor, user and peripheral indices meet.
- The held value returned while the core re-halts.
- The status word.
- That one step gives exactly one pulse, counted across the whole halt-again sequence.

// File: rtl/dbg_pkg.sv
package dbg_pkg;
    localparam int DATA_W = 32;
    localparam int IDX_W  = 6;

    // control register command bit positions
    localparam int CMD_HALT  = 8;
    localparam int CMD_STEP  = 9;
    localparam int CMD_GO    = 10;
    localparam int CMD_RESET = 11;
    localparam int FLAG_RDY  = 12;

    // status word bit positions
    localparam int STS_SLEEP = 12;
    localparam int STS_SUPER = 13;
    localparam int STS_BREAK = 15;
    localparam int STS_EXTI  = 16;

    typedef enum logic [2:0] {
        ST_RUN,
        ST_HALT_WAIT,
        ST_HALTED,
        ST_STEP,
        ST_RESET
    } dbg_state_e;

    typedef struct packed {
        logic wr;
        logic halt;
        logic step;
        logic go;
        logic rst;
    } dbg_cmd_t;
endpackage

// File: rtl/dbg_ctrl_fsm.sv
module dbg_ctrl_fsm
    import dbg_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  dbg_cmd_t   cmd,
    input  logic       core_halted,
    output dbg_state_e state,
    output logic       core_halt_req,
    output logic       core_reset,
    output logic       core_step
);
    dbg_state_e state_q, state_d;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_RUN;
        else        state_q <= state_d;
    end

    // next state: reset > go > step > halt
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN: begin
                if (cmd.wr) begin
                    if (cmd.rst)                   state_d = ST_RESET;
                    else if (cmd.go)               state_d = ST_RUN;
                    else if (cmd.step || cmd.halt) state_d = ST_HALT_WAIT;
                end
            end
            ST_HALT_WAIT: begin
                if (cmd.wr && cmd.rst)     state_d = ST_RESET;
                else if (cmd.wr && cmd.go) state_d = ST_RUN;
                else if (core_halted)      state_d = ST_HALTED;
            end
            ST_HALTED: begin
                if (cmd.wr) begin
                    if (cmd.rst)       state_d = ST_RESET;
                    else if (cmd.go)   state_d = ST_RUN;
                    else if (cmd.step) state_d = ST_STEP;
                end
            end
            ST_STEP:  state_d = ST_HALT_WAIT;
            ST_RESET: state_d = ST_HALT_WAIT;
            default:  state_d = ST_RUN;
        endcase
    end

    // outputs
    always_comb begin
        core_halt_req = 1'b1;
        core_reset    = 1'b0;
        core_step     = 1'b0;
        unique case (state_q)
            ST_RUN:       core_halt_req = 1'b0;
            ST_HALT_WAIT: ;
            ST_HALTED:    ;
            ST_STEP:      core_step  = 1'b1;
            ST_RESET:     core_reset = 1'b1;
            default:      core_halt_req = 1'b0;
        endcase
    end

    assign state = state_q;
endmodule

// File: rtl/dbg_index_decode.sv
module dbg_index_decode #(
    parameter int DW = 32,
    parameter int IW = 6
) (
    input  logic [IW-1:0] idx,
    input  logic [DW-1:0] cpu_reg_val,
    input  logic [DW-1:0] per_val,
    output logic [4:0]    cpu_reg_sel,
    output logic [3:0]    per_sel,
    output logic [DW-1:0] sel_val
);
    localparam logic [1:0] GRP_PER = 2'b10;

    logic is_cpu, is_per;

    assign cpu_reg_sel = idx[4:0];
    assign per_sel     = idx[3:0];
    assign is_cpu      = (idx[IW-1] == 1'b0);
    // peripherals: 32..39 and 44..47; 40..43 left unmapped
    assign is_per      = (idx[IW-1:IW-2] == GRP_PER) &&
                         (!idx[3] || (idx[3:2] == 2'b11));

    always_comb begin
        if (is_cpu)      sel_val = cpu_reg_val;
        else if (is_per) sel_val = per_val;
        else             sel_val = '0;
    end
endmodule

// File: rtl/dbg_capture.sv
module dbg_capture #(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          halted_st,
    input  logic          ctrl_wr,
    input  logic [DW-1:0] sel_val,
    output logic [DW-1:0] data_q,
    output logic          ready_q
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q  <= '0;
            ready_q <= 1'b0;
        end else begin
            ready_q <= halted_st && !ctrl_wr;
            if (halted_st) data_q <= sel_val;
        end
    end
endmodule

// File: rtl/dbg_port.sv
module dbg_port
    import dbg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              core_halt_req,
    output logic              core_reset,
    output logic              core_step,
    input  logic              core_halted,
    output logic [4:0]        cpu_reg_sel,
    input  logic [DATA_W-1:0] cpu_reg_val,
    output logic [3:0]        per_sel,
    input  logic [DATA_W-1:0] per_val,
    input  logic              st_ext_int,
    input  logic              st_break_en,
    input  logic              st_supervisor,
    input  logic              st_sleeping
);
    dbg_cmd_t          cmd;
    dbg_state_e        state;
    logic [IDX_W-1:0]  idx_q;
    logic [DATA_W-1:0] sel_val, data_q, ctrl_word, status_word;
    logic              ready_q, ctrl_wr;

    assign ctrl_wr  = bus_wr && (bus_addr == 1'b0);
    assign cmd.wr   = ctrl_wr;
    assign cmd.halt = bus_wdata[CMD_HALT];
    assign cmd.step = bus_wdata[CMD_STEP];
    assign cmd.go   = bus_wdata[CMD_GO];
    assign cmd.rst  = bus_wdata[CMD_RESET];

    always_ff @(posedge clk) begin
        if (!rst_n)       idx_q <= '0;
        else if (ctrl_wr) idx_q <= bus_wdata[IDX_W-1:0];
    end

    dbg_ctrl_fsm u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .cmd           (cmd),
        .core_halted   (core_halted),
        .state         (state),
        .core_halt_req (core_halt_req),
        .core_reset    (core_reset),
        .core_step     (core_step)
    );

    dbg_index_decode #(.DW(DATA_W), .IW(IDX_W)) u_dec (
        .idx         (idx_q),
        .cpu_reg_val (cpu_reg_val),
        .per_val     (per_val),
        .cpu_reg_sel (cpu_reg_sel),
        .per_sel     (per_sel),
        .sel_val     (sel_val)
    );

    dbg_capture #(.DW(DATA_W)) u_cap (
        .clk       (clk),
        .rst_n     (rst_n),
        .halted_st (state == ST_HALTED),
        .ctrl_wr   (ctrl_wr),
        .sel_val   (sel_val),
        .data_q    (data_q),
        .ready_q   (ready_q)
    );

    always_comb begin
        ctrl_word              = '0;
        ctrl_word[IDX_W-1:0]   = idx_q;
        ctrl_word[CMD_HALT]    = core_halt_req;
        ctrl_word[FLAG_RDY]    = ready_q;
        status_word            = '0;
        status_word[STS_EXTI]  = st_ext_int;
        status_word[STS_BREAK] = st_break_en;
        status_word[STS_SUPER] = st_supervisor;
        status_word[STS_SLEEP] = st_sleeping;
    end

    always_comb begin
        if (!bus_addr)           bus_rdata = ctrl_word;
        else if (state == ST_RUN) bus_rdata = status_word;
        else                     bus_rdata = data_q;
    end
endmodule

// File: rtl/dbg_port_chk.sv
module dbg_port_chk
    import dbg_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr,
    input logic              bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [DATA_W-1:0] bus_rdata,
    input logic              core_halt_req,
    input logic              core_reset,
    input logic              core_step,
    input logic              ready_q,
    input logic [IDX_W-1:0]  idx_q
);
    logic ctrl_wr;
    assign ctrl_wr = bus_wr && !bus_addr;

    // R5
    step_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        core_step |=> !core_step);
    // R6
    reset_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        core_reset |=> !core_reset);
    // R6
    reset_halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        core_reset |-> core_halt_req);
    // R7
    ready_halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ready_q |-> core_halt_req);
    // R7
    ready_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_wr |=> !ready_q);
    // R4
    go_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && bus_wdata[CMD_GO] && !bus_wdata[CMD_RESET] && !core_step && !core_reset)
        |=> !core_halt_req);
    // R13
    step_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && !core_halt_req && bus_wdata[CMD_STEP] && !bus_wdata[CMD_RESET])
        |=> !core_step);
    // R10
    unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ready_q && bus_addr && ((idx_q[5:4] == 2'b11) || (idx_q[5:2] == 4'b1010)))
        |-> (bus_rdata == '0));
endmodule

bind dbg_port dbg_port_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .bus_wr        (bus_wr),
    .bus_addr      (bus_addr),
    .bus_wdata     (bus_wdata),
    .bus_rdata     (bus_rdata),
    .core_halt_req (core_halt_req),
    .core_reset    (core_reset),
    .core_step     (core_step),
    .ready_q       (ready_q),
    .idx_q         (idx_q)
);

// File: tb/test_dbg_port.sv
`timescale 1ns/1ps
module test_dbg_port;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic        bus_addr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        core_halt_req, core_reset, core_step;
    logic        core_halted;
    logic [4:0]  cpu_reg_sel;
    logic [3:0]  per_sel;
    logic [31:0] cpu_reg_val, per_val;
    logic        st_ext_int = 1'b0, st_break_en = 1'b0;
    logic        st_supervisor = 1'b0, st_sleeping = 1'b0;

    int checks = 0;
    int fails  = 0;
    int steps  = 0;
    int resets = 0;
    int busy   = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    dbg_port i_dbg_port (.*);

    // core model
    assign cpu_reg_val = 32'hA000_0000 | {27'd0, cpu_reg_sel};
    assign per_val     = 32'hB000_0000 | {28'd0, per_sel};

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            core_halted <= 1'b0;
            busy        <= 0;
        end else if (core_step || core_reset) begin
            core_halted <= 1'b0;
            busy        <= 3;
        end else if (busy != 0) begin
            busy <= busy - 1;
        end else begin
            core_halted <= core_halt_req;
        end
    end

    always_ff @(posedge clk) begin
        if (core_step)  steps  <= steps + 1;
        if (core_reset) resets <= resets + 1;
    end

    // index vectors: {index, expected value}
    localparam logic [37:0] VEC [12] = '{
        {6'd0,  32'hA000_0000}, {6'd15, 32'hA000_000F},
        {6'd16, 32'hA000_0010}, {6'd31, 32'hA000_001F},
        {6'd32, 32'hB000_0000}, {6'd39, 32'hB000_0007},
        {6'd40, 32'h0000_0000}, {6'd43, 32'h0000_0000},
        {6'd44, 32'hB000_000C}, {6'd47, 32'hB000_000F},
        {6'd48, 32'h0000_0000}, {6'd63, 32'h0000_0000}
    };

    localparam logic [31:0] C_HALT = 32'h100;
    localparam logic [31:0] C_STEP = 32'h200;
    localparam logic [31:0] C_GO   = 32'h400;
    localparam logic [31:0] C_RST  = 32'h800;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr_ctrl(input logic [31:0] v);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = 1'b0; bus_wdata = v;
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd(input logic a, output logic [31:0] v);
        bus_addr = a;
        #1;
        v = bus_rdata;
    endtask

    task automatic wait_ready(output logic ok);
        logic [31:0] v;
        ok = 1'b0;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            rd(1'b0, v);
            if (v[12]) begin ok = 1'b1; break; end
        end
    endtask

    initial begin
        logic [31:0] v;
        logic ok;
        int s0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(1'b0, v);
        chk("R1 ctrl", v, 32'h0);
        chk("R1 halt_req", {31'd0, core_halt_req}, 32'd0);

        // R12 status word while running
        st_ext_int = 1'b1; st_break_en = 1'b1; st_supervisor = 1'b0; st_sleeping = 1'b1;
        rd(1'b1, v);
        chk("R12 status", v, 32'h0001_9000);
        st_ext_int = 1'b0; st_supervisor = 1'b1;
        rd(1'b1, v);
        chk("R12 status2", v, 32'h0000_B000);

        // R13 step while running halts without pulse
        s0 = steps;
        wr_ctrl(C_STEP | 32'd5);
        chk("R13 halt_req", {31'd0, core_halt_req}, 32'd1);
        wait_ready(ok);
        chk("R13 ready", {31'd0, ok}, 32'd1);
        chk("R13 no pulse", steps - s0, 32'd0);
        rd(1'b1, v);
        chk("R8 idx5", v, 32'hA000_0005);
        rd(1'b0, v);
        chk("R2 ctrl read", v, 32'h0000_1105);

        // R8 R9 R10 vector table
        foreach (VEC[k]) begin
            wr_ctrl(C_HALT | {26'd0, VEC[k][37:32]});
            rd(1'b0, v);
            chk("R7 ready drop", {31'd0, v[12]}, 32'd0);
            wait_ready(ok);
            rd(1'b1, v);
            chk("R8/R9/R10 index read", v, VEC[k][31:0]);
        end

        // R5 step while halted, R11 held value during step
        wr_ctrl(C_HALT | 32'd3);
        wait_ready(ok);
        s0 = steps;
        wr_ctrl(C_STEP | 32'd3);
        chk("R5 pulse", {31'd0, core_step}, 32'd1);
        @(negedge clk);
        chk("R5 single", {31'd0, core_step}, 32'd0);
        chk("R5 halt held", {31'd0, core_halt_req}, 32'd1);
        rd(1'b1, v);
        chk("R11 held value", v, 32'hA000_0003);
        rd(1'b0, v);
        chk("R11 not ready", {31'd0, v[12]}, 32'd0);
        wait_ready(ok);
        chk("R5 ready again", {31'd0, ok}, 32'd1);
        chk("R5 one step", steps - s0, 32'd1);

        // R6 reset with halt
        s0 = resets;
        wr_ctrl(C_RST | C_HALT | 32'd17);
        chk("R6 pulse", {31'd0, core_reset}, 32'd1);
        chk("R6 halt", {31'd0, core_halt_req}, 32'd1);
        wait_ready(ok);
        chk("R6 halted after", {31'd0, ok}, 32'd1);
        chk("R6 one reset", resets - s0, 32'd1);
        rd(1'b1, v);
        chk("R8 user idx17", v, 32'hA000_0011);

        // R2 priority: reset beats go/step/halt
        s0 = steps;
        wr_ctrl(C_RST | C_GO | C_STEP | C_HALT);
        chk("R2 reset wins", {31'd0, core_reset}, 32'd1);
        wait_ready(ok);
        // R2 go beats step
        wr_ctrl(C_GO | C_STEP);
        chk("R2 go wins", {31'd0, core_halt_req}, 32'd0);
        @(negedge clk);
        chk("R2 no step", steps - s0, 32'd0);

        // R3 halt sticky, R4 go releases
        wr_ctrl(C_HALT);
        chk("R3 halt", {31'd0, core_halt_req}, 32'd1);
        wait_ready(ok);
        wr_ctrl(32'd7);
        chk("R3 sticky", {31'd0, core_halt_req}, 32'd1);
        wait_ready(ok);
        wr_ctrl(C_GO);
        chk("R4 released", {31'd0, core_halt_req}, 32'd0);
        rd(1'b0, v);
        chk("R4 ready clear", {31'd0, v[12]}, 32'd0);

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #(8 * 200000);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule